// File: doc/BRIEF.md
# Page Table Walk Translator

This block turns a logical address from a processor into a physical address when the page table lives in main memory. The low `OFF_W` bits of the logical address are the byte offset inside a page and the bits above them are the page number. Each translation reads one page-table entry from memory at the word address base + page number. The entry is checked, and the physical address is formed by placing the entry's frame number above the unchanged offset.

Two configuration registers, a table base and a table length, are written through simple write strobes. A request is accepted only while the unit is idle, so one walk is in flight at a time. The controller has four named states: `ST_IDLE` (waits for a request), `ST_FETCH_PTE` (issues the single-cycle entry read), `ST_WAIT_PTE` (waits for read data) and `ST_RESPOND` (drives the one-cycle response). Transitions: `ST_IDLE -> ST_FETCH_PTE` on an accepted in-range request; `ST_IDLE -> ST_RESPOND` on an accepted request whose page number is out of range; `ST_FETCH_PTE -> ST_WAIT_PTE` always; `ST_WAIT_PTE -> ST_RESPOND` when read data returns; `ST_RESPOND -> ST_IDLE` always.

Entry word layout, from bit 0 upward: bit 0 executable, bit 1 writable, bit 2 valid, bits `[PTE_W-1:3]` frame number. Access kinds on `req_kind`: 0 data read, 1 data write, 2 instruction fetch, 3 treated as data read. Fault codes on `rsp_cause`: 0 none, 1 length, 2 invalid entry, 3 protection.

Top module: `ptw_translator`

## Requirements
- R1: A successful response carries physical address {frame number from the entry, offset bits `req_vaddr[OFF_W-1:0]` unchanged}; the page number is `req_vaddr[VA_W-1:OFF_W]`.
- R2: A walk issues exactly one entry read, with `mem_addr` equal to (table base + page number) modulo 2^MA_W, driven for one cycle in the cycle after acceptance.
- R3: A page number greater than or equal to the table length gives cause 1 with no memory read, and `rsp_valid` rises in the cycle after acceptance.
- R4: An entry with valid bit (bit 2) clear gives cause 2, whatever the access kind.
- R5: A write (kind 1) to an entry with writable bit (bit 1) clear, or a fetch (kind 2) from an entry with executable bit (bit 0) clear, gives cause 3; kinds 0 and 3 need only the valid bit.
- R6: Any faulting response carries physical address zero; a length fault takes priority over the entry checks, and an invalid entry takes priority over protection.
- R7: `req_ready` is high only in `ST_IDLE`; `rsp_valid` is a one-cycle pulse that rises one cycle after `mem_rd_valid` is seen in `ST_WAIT_PTE`.
- R8: After reset the unit is idle with `req_ready` high, `rsp_valid` and `mem_rd_en` low, table base 0 and table length 0, so every request then takes a length fault.
- R9: Writes to the base or length registers during a walk do not change that walk; they apply from the next accepted request.
- R10: `mem_rd_valid` outside `ST_WAIT_PTE` is ignored: no response and no change to `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base_we | input | 1 | Write strobe for the table base register |
| cfg_base | input | MA_W | New table base word address |
| cfg_len_we | input | 1 | Write strobe for the table length register |
| cfg_len | input | VA_W-OFF_W+1 | New table length in entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | VA_W | Logical address |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 fetch, 3 read) |
| mem_rd_en | output | 1 | Entry read strobe, one cycle |
| mem_addr | output | MA_W | Entry word address |
| mem_rd_valid | input | 1 | Entry read data present |
| mem_rd_data | input | PA_W-OFF_W+3 | Entry word |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | PA_W | Physical address, zero on a fault |
| rsp_cause | output | 2 | Fault code |

## Verification
The bench sweeps every page number under three base values (one that wraps the memory address), three table lengths (full, partial, zero) and all four access kinds, with read latencies of one to three cycles. It targets the page number equal to the length, where an off-by-one compare would issue a read or translate a page that must fault, and entries whose flags collide, where a wrong priority would report protection on an invalid entry or a translation on a read-only write. A mid-walk rewrite of base and length catches a design that reads the live registers instead of a snapshot, and a stray read-data pulse while idle catches a controller that leaves `ST_IDLE` on it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FETCH_PTE = 2'd1,
        ST_WAIT_PTE  = 2'd2,
        ST_RESPOND   = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_LENGTH  = 2'd1,
        CAUSE_INVALID = 2'd2,
        CAUSE_PROTECT = 2'd3
    } fault_cause_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_kind_e;

    localparam int PTE_X_BIT     = 0;
    localparam int PTE_W_BIT     = 1;
    localparam int PTE_V_BIT     = 2;
    localparam int PTE_FRAME_LSB = 3;

endpackage

// File: rtl/ptw_cfg_regs.sv
module ptw_cfg_regs #(
    parameter int MA_W  = 6,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_we,
    input  logic [MA_W-1:0]  base_in,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_in,
    output logic [MA_W-1:0]  base_q,
    output logic [LEN_W-1:0] len_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (base_we) begin
            base_q <= base_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (len_we) begin
            len_q <= len_in;
        end
    end

endmodule

// File: rtl/ptw_addr_split.sv
module ptw_addr_split #(
    parameter int VA_W = 8,
    parameter int OFF_W = 4,
    parameter int MA_W = 6
) (
    input  logic [VA_W-1:0]        vaddr,
    input  logic [MA_W-1:0]        base,
    input  logic [VA_W-OFF_W:0]    len,
    output logic [OFF_W-1:0]       offset,
    output logic [MA_W-1:0]        pte_addr,
    output logic                   out_of_range
);

    localparam int PG_W = VA_W - OFF_W;

    logic [PG_W-1:0] page;
    logic [MA_W-1:0] page_ext;

    assign page   = vaddr[VA_W-1:OFF_W];
    assign offset = vaddr[OFF_W-1:0];

    generate
        if (PG_W >= MA_W) begin : g_page_trunc
            assign page_ext = page[MA_W-1:0];
        end else begin : g_page_zext
            assign page_ext = {{(MA_W-PG_W){1'b0}}, page};
        end
    endgenerate

    assign pte_addr     = base + page_ext;
    assign out_of_range = ({1'b0, page} >= len);

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
#(
    parameter int FRM_W = 6,
    parameter int OFF_W = 4
) (
    input  logic [FRM_W+2:0]      pte,
    input  access_kind_e          kind,
    input  logic [OFF_W-1:0]      offset,
    output fault_cause_e          cause,
    output logic [FRM_W+OFF_W-1:0] paddr
);

    logic             ent_valid;
    logic             ent_write;
    logic             ent_exec;
    logic [FRM_W-1:0] frame;
    logic             prot_bad;

    assign ent_valid = pte[PTE_V_BIT];
    assign ent_write = pte[PTE_W_BIT];
    assign ent_exec  = pte[PTE_X_BIT];
    assign frame     = pte[PTE_FRAME_LSB +: FRM_W];

    always_comb begin
        prot_bad = 1'b0;
        unique case (kind)
            ACC_WRITE: prot_bad = !ent_write;
            ACC_EXEC:  prot_bad = !ent_exec;
            ACC_READ,
            ACC_RSVD:  prot_bad = 1'b0;
        endcase
    end

    always_comb begin
        if (!ent_valid) begin
            cause = CAUSE_INVALID;
        end else if (prot_bad) begin
            cause = CAUSE_PROTECT;
        end else begin
            cause = CAUSE_NONE;
        end
    end

    assign paddr = (cause == CAUSE_NONE) ? {frame, offset} : '0;

endmodule

// File: rtl/ptw_translator.sv
module ptw_translator
    import ptw_pkg::*;
#(
    parameter int VA_W  = 8,
    parameter int OFF_W = 4,
    parameter int PA_W  = 10,
    parameter int MA_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_base_we,
    input  logic [MA_W-1:0]         cfg_base,
    input  logic                    cfg_len_we,
    input  logic [VA_W-OFF_W:0]     cfg_len,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [VA_W-1:0]         req_vaddr,
    input  logic [1:0]              req_kind,
    output logic                    mem_rd_en,
    output logic [MA_W-1:0]         mem_addr,
    input  logic                    mem_rd_valid,
    input  logic [PA_W-OFF_W+2:0]   mem_rd_data,
    output logic                    rsp_valid,
    output logic [PA_W-1:0]         rsp_paddr,
    output logic [1:0]              rsp_cause
);

    localparam int PG_W  = VA_W - OFF_W;
    localparam int LEN_W = PG_W + 1;
    localparam int FRM_W = PA_W - OFF_W;

    walk_state_e      state_q;
    walk_state_e      state_d;

    logic [MA_W-1:0]  base_q;
    logic [LEN_W-1:0] len_q;

    logic [OFF_W-1:0] split_off;
    logic [MA_W-1:0]  split_addr;
    logic             split_oor;

    logic [OFF_W-1:0] off_q;
    access_kind_e     kind_q;
    logic [MA_W-1:0]  addr_q;
    fault_cause_e     cause_q;
    logic [PA_W-1:0]  paddr_q;

    fault_cause_e     chk_cause;
    logic [PA_W-1:0]  chk_paddr;

    logic             accept;

    ptw_cfg_regs #(
        .MA_W  (MA_W),
        .LEN_W (LEN_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_we (cfg_base_we),
        .base_in (cfg_base),
        .len_we  (cfg_len_we),
        .len_in  (cfg_len),
        .base_q  (base_q),
        .len_q   (len_q)
    );

    ptw_addr_split #(
        .VA_W  (VA_W),
        .OFF_W (OFF_W),
        .MA_W  (MA_W)
    ) u_split (
        .vaddr        (req_vaddr),
        .base         (base_q),
        .len          (len_q),
        .offset       (split_off),
        .pte_addr     (split_addr),
        .out_of_range (split_oor)
    );

    ptw_pte_check #(
        .FRM_W (FRM_W),
        .OFF_W (OFF_W)
    ) u_check (
        .pte    (mem_rd_data),
        .kind   (kind_q),
        .offset (off_q),
        .cause  (chk_cause),
        .paddr  (chk_paddr)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = split_oor ? ST_RESPOND : ST_FETCH_PTE;
                end
            end
            ST_FETCH_PTE: state_d = ST_WAIT_PTE;
            ST_WAIT_PTE: begin
                if (mem_rd_valid) begin
                    state_d = ST_RESPOND;
                end
            end
            ST_RESPOND: state_d = ST_IDLE;
        endcase
    end

    // walk context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q   <= '0;
            kind_q  <= ACC_READ;
            addr_q  <= '0;
            cause_q <= CAUSE_NONE;
            paddr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        off_q  <= split_off;
                        kind_q <= access_kind_e'(req_kind);
                        addr_q <= split_addr;
                        if (split_oor) begin
                            cause_q <= CAUSE_LENGTH;
                            paddr_q <= '0;
                        end
                    end
                end
                ST_WAIT_PTE: begin
                    if (mem_rd_valid) begin
                        cause_q <= chk_cause;
                        paddr_q <= chk_paddr;
                    end
                end
                ST_FETCH_PTE,
                ST_RESPOND: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_rd_en = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_FETCH_PTE: mem_rd_en = 1'b1;
            ST_WAIT_PTE:  ;
            ST_RESPOND:   rsp_valid = 1'b1;
        endcase
    end

    assign mem_addr  = addr_q;
    assign rsp_paddr = paddr_q;
    assign rsp_cause = cause_q;

endmodule

// File: rtl/ptw_translator_chk.sv
module ptw_translator_chk #(
    parameter int VA_W  = 8,
    parameter int OFF_W = 4,
    parameter int PA_W  = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [VA_W-1:0]      req_vaddr,
    input logic [VA_W-OFF_W:0]  len_q,
    input logic                 mem_rd_en,
    input logic                 rsp_valid,
    input logic [PA_W-1:0]      rsp_paddr,
    input logic [1:0]           rsp_cause
);

    logic [OFF_W-1:0] seen_off;
    logic             seen_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_off <= '0;
            seen_any <= 1'b0;
        end else if (req_valid && req_ready) begin
            seen_off <= req_vaddr[OFF_W-1:0];
            seen_any <= 1'b1;
        end
    end

    p_rd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    p_len_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_vaddr[VA_W-1:OFF_W]} >= len_q))
        |=> (rsp_valid && rsp_cause == 2'd1 && !mem_rd_en));

    p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause != 2'd0) |-> (rsp_paddr == '0));

    p_busy_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && seen_any && rsp_cause == 2'd0)
        |-> (rsp_paddr[OFF_W-1:0] == seen_off));

endmodule

bind ptw_translator ptw_translator_chk #(
    .VA_W  (VA_W),
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .len_q     (len_q),
    .mem_rd_en (mem_rd_en),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_cause (rsp_cause)
);

// File: tb/ptw_translator_test.sv
`timescale 1ns/1ps
module ptw_translator_test;

    localparam int VA_W  = 8;
    localparam int OFF_W = 4;
    localparam int PA_W  = 10;
    localparam int MA_W  = 6;
    localparam int FRM_W = PA_W - OFF_W;
    localparam int PTE_W = FRM_W + 3;
    localparam int LEN_W = VA_W - OFF_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_base_we = 1'b0;
    logic [MA_W-1:0]  cfg_base = '0;
    logic             cfg_len_we = 1'b0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic [1:0]       req_kind = '0;
    logic             mem_rd_en;
    logic [MA_W-1:0]  mem_addr;
    logic             mem_rd_valid = 1'b0;
    logic [PTE_W-1:0] mem_rd_data = '0;
    logic             rsp_valid;
    logic [PA_W-1:0]  rsp_paddr;
    logic [1:0]       rsp_cause;

    int checks = 0;
    int errors = 0;

    int mem_lat = 1;
    int pend_cnt = 0;
    logic [MA_W-1:0] pend_addr = '0;
    int reads = 0;
    logic [MA_W-1:0] last_addr = '0;
    logic stray = 1'b0;

    always #4 clk = ~clk;

    ptw_translator #(
        .VA_W (VA_W), .OFF_W (OFF_W), .PA_W (PA_W), .MA_W (MA_W)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .cfg_base_we (cfg_base_we), .cfg_base (cfg_base),
        .cfg_len_we (cfg_len_we), .cfg_len (cfg_len),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_vaddr (req_vaddr), .req_kind (req_kind),
        .mem_rd_en (mem_rd_en), .mem_addr (mem_addr),
        .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
        .rsp_valid (rsp_valid), .rsp_paddr (rsp_paddr), .rsp_cause (rsp_cause)
    );

    // Entry word for a table address: bit0 exec, bit1 write, bit2 valid, frame above
    function automatic logic [PTE_W-1:0] pte_word(input int a);
        logic [FRM_W-1:0] fr;
        fr = FRM_W'((a * 5 + 3) % (1 << FRM_W));
        return {fr, ((a % 5) != 0) ? 1'b1 : 1'b0,
                    ((a % 3) != 0) ? 1'b1 : 1'b0,
                    ((a % 2) == 0) ? 1'b1 : 1'b0};
    endfunction

    // memory model, driven away from the active edge
    always @(negedge clk) begin
        if (pend_cnt != 0) begin
            pend_cnt = pend_cnt - 1;
            if (pend_cnt == 0) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = pte_word(int'(pend_addr));
            end else begin
                mem_rd_valid = 1'b0;
            end
        end else begin
            mem_rd_valid = stray;
            mem_rd_data  = stray ? '1 : '0;
        end
        if (mem_rd_en) begin
            reads     = reads + 1;
            last_addr = mem_addr;
            pend_addr = mem_addr;
            pend_cnt  = mem_lat;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int base, input int len);
        @(negedge clk);
        cfg_base_we = 1'b1; cfg_base = MA_W'(base);
        cfg_len_we  = 1'b1; cfg_len  = LEN_W'(len);
        @(negedge clk);
        cfg_base_we = 1'b0; cfg_len_we = 1'b0;
    endtask

    // one transaction; poke rewrites base to 40 and length to 0 mid-walk
    task automatic xact(input int va, input int kind, input int lat, input bit poke,
                        output int cause, output int paddr, output int nrd,
                        output int addr, output int latency);
        int n;
        mem_lat = lat;
        @(negedge clk);
        reads = 0;
        req_valid = 1'b1;
        req_vaddr = VA_W'(va);
        req_kind  = 2'(kind);
        @(posedge clk);
        n = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            n++;
            if (poke && n == 1) begin
                cfg_base_we = 1'b1; cfg_base = MA_W'(40);
                cfg_len_we  = 1'b1; cfg_len  = '0;
            end else begin
                cfg_base_we = 1'b0; cfg_len_we = 1'b0;
            end
        end while (!rsp_valid && n < 40);
        cfg_base_we = 1'b0; cfg_len_we = 1'b0;
        cause   = int'(rsp_cause);
        paddr   = int'(rsp_paddr);
        nrd     = reads;
        addr    = int'(last_addr);
        latency = n;
    endtask

    task automatic expect_xact(input int base, input int len, input int va,
                               input int kind, input int lat,
                               output int ecause, output int epaddr, output int enrd,
                               output int eaddr, output int elat);
        int page;
        int off;
        logic [PTE_W-1:0] w;
        page = va >> OFF_W;
        off  = va % (1 << OFF_W);
        if (page >= len) begin
            ecause = 1; epaddr = 0; enrd = 0; eaddr = -1; elat = 1;
        end else begin
            eaddr = (base + page) % (1 << MA_W);
            w = pte_word(eaddr);
            enrd = 1; elat = 2 + lat;
            if (!w[2]) ecause = 2;
            else if ((kind == 1 && !w[1]) || (kind == 2 && !w[0])) ecause = 3;
            else ecause = 0;
            epaddr = (ecause == 0) ? (int'(w[PTE_W-1:3]) * (1 << OFF_W) + off) : 0;
        end
    endtask

    task automatic run_and_compare(input int base, input int len, input int va,
                                   input int kind, input int lat, input bit poke);
        int c, p, r, a, l;
        int ec, ep, er, ea, el;
        xact(va, kind, lat, poke, c, p, r, a, l);
        expect_xact(base, len, va, kind, lat, ec, ep, er, ea, el);
        if (ec == 1)      check(c == ec, "R3", "cause", c, ec);
        else if (ec == 2) check(c == ec, "R4", "cause", c, ec);
        else if (ec == 3) check(c == ec, "R5", "cause", c, ec);
        else              check(c == ec, "R5", "cause", c, ec);
        if (ec == 0) check(p == ep, "R1", "paddr", p, ep);
        else         check(p == ep, "R6", "fault paddr", p, ep);
        check(r == er, (ec == 1) ? "R3" : "R2", "read count", r, er);
        if (er == 1) check(a == ea, "R2", "pte address", a, ea);
        check(l == el, (ec == 1) ? "R3" : "R7", "response latency", l, el);
        if (poke) check(a == ea, "R9", "poked walk address", a, ea);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int bases[3];
        int lens[3];
        int lat;
        bases = '{0, 10, 60};
        lens  = '{16, 7, 0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(req_ready == 1'b1, "R8", "req_ready", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R8", "rsp_valid", int'(rsp_valid), 0);
        check(mem_rd_en == 1'b0, "R8", "mem_rd_en", int'(mem_rd_en), 0);
        // R8: length 0 and base 0 after reset
        run_and_compare(0, 0, 8'h35, 0, 1, 1'b0);

        // R10: stray read data while idle
        @(negedge clk);
        stray = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(rsp_valid == 1'b0, "R10", "stray rsp_valid", int'(rsp_valid), 0);
            check(req_ready == 1'b1, "R10", "stray req_ready", int'(req_ready), 1);
        end
        stray = 1'b0;
        @(negedge clk);

        // sweep: bases x lengths x pages x kinds, latencies cycling
        lat = 1;
        foreach (bases[bi]) begin
            foreach (lens[li]) begin
                set_cfg(bases[bi], lens[li]);
                for (int pg = 0; pg < 16; pg++) begin
                    for (int k = 0; k < 4; k++) begin
                        int va;
                        va = pg * 16 + ((pg * 7 + k * 3 + bases[bi]) % 16);
                        run_and_compare(bases[bi], lens[li], va, k, lat, 1'b0);
                        lat = (lat % 3) + 1;
                    end
                end
            end
        end

        // R9: configuration rewrite during a walk
        set_cfg(10, 16);
        run_and_compare(10, 16, 8'h2B, 0, 3, 1'b1);
        run_and_compare(40, 0, 8'h2B, 0, 1, 1'b0);   // new length applies
        set_cfg(40, 16);
        run_and_compare(40, 16, 8'h2B, 0, 2, 1'b0);  // new base applies

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule